// File: doc/BRIEF.md
# Triggered Hit-Frame Event Store

This block keeps the events of a multi-channel binary-threshold front-end. Every channel delivers a 2-bit discriminator level. The block gathers these levels over each bunch crossing. When the crossing-end strobe arrives and at least one bit was active during that crossing, it writes one frame. The frame holds a snapshot of every channel, the crossing number and an 8-bit header that identifies the chip. Channels that stayed quiet are stored as well, so each frame has the same fixed size.

A free-running crossing counter provides the timestamp. The counter advances on every strobe and restarts when a new acquisition begins. The store keeps a fixed number of frames. When it fills, it raises a full flag and refuses new captures until a readout has drained it completely. Readout is a simple pull interface: each accepted request returns the oldest frame not yet read, one cycle later.

Top module: `hf_event_store`

## Requirements
- R1: While and just after reset, `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R2: A frame is packed as follows. Channel c's two bits sit at [2c+1:2c]. The crossing number occupies the BCID_W bits directly above all channel bits. The top HDR_W bits hold the `chip_id` value present on the strobe cycle.
- R3: A strobe writes a frame only if some discriminator bit was 1 on at least one cycle of that crossing. A crossing spans from the cycle after the previous strobe up to and including the strobe cycle. A crossing with no active bit leaves the store unchanged.
- R4: The frame carries all channels. Each bit is the OR of that channel's level over the whole crossing, so several active cycles within one crossing give exactly one frame.
- R5: The stored crossing number counts the strobes seen since the last acquisition start: 0 for the first crossing, then +1 per strobe, wrapping modulo 2^BCID_W.
- R6: `acq_start` clears the crossing counter and discards the levels gathered so far. If it coincides with a strobe, no frame is written for that crossing.
- R7: After DEPTH frames are held, `full` rises on the same edge that stores the last frame. Crossings with hits are then ignored and the count never exceeds DEPTH.
- R8: Once raised, `full` stays 1 and captures stay blocked until every held frame has been read. `full` drops on the edge that pops the last frame, and `full` and `empty` are never both 1.
- R9: A cycle with `rd_en`=1 while not empty gives `rd_valid`=1 on the next cycle, with the oldest unread frame on `rd_frame`. `rd_en` while empty is ignored and gives `rd_valid`=0.
- R10: When not full, a capture and a read in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start | input | 1 | Start of acquisition: clears crossing counter and gathered levels |
| bx_strobe | input | 1 | Marks the last cycle of a bunch crossing |
| disc | input | 2*NCH | Per-channel 2-bit discriminator levels |
| chip_id | input | HDR_W | Header value stored in each frame |
| rd_en | input | 1 | Readout request |
| rd_valid | output | 1 | `rd_frame` holds a frame this cycle |
| rd_frame | output | 2*NCH+BCID_W+HDR_W | Oldest unread frame |
| full | output | 1 | Store full, capture blocked |
| empty | output | 1 | No frame held |

## Verification
A frame is written on the clock edge that ends its strobe cycle. `full` and `empty` reflect that write one cycle after the strobe is driven. A read request gives `rd_valid` and the frame one cycle after `rd_en` is driven. The bench drives every input on the falling edge and samples all results on the next falling edge, halfway after the single register stage that produces them. A model queue built from the stimulus supplies the expected frames, header values and crossing numbers. Whenever the full/empty state changes it also supplies the expected flags, following the same push-before-flag ordering given in the requirements.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam int unsigned HIT_BITS = 2;

  function automatic int unsigned frame_width(input int unsigned nch,
                                              input int unsigned bw,
                                              input int unsigned hw);
    return HIT_BITS * nch + bw + hw;
  endfunction
endpackage

// File: rtl/hf_bx_counter.sv
module hf_bx_counter #(
  parameter int unsigned BW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [BW-1:0] bcid
);
  logic [BW-1:0] bcid_q;
  logic [BW-1:0] bcid_d;
  logic          bcid_en;

  always_comb begin
    bcid_en = clr | step;
    if (clr) bcid_d = '0;
    else     bcid_d = bcid_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bcid_q <= '0;
    else if (bcid_en) bcid_q <= bcid_d;
  end

  assign bcid = bcid_q;
endmodule

// File: rtl/hf_hit_accum.sv
module hf_hit_accum #(
  parameter int unsigned NCH = 64,
  localparam int unsigned HW_ = hf_pkg::HIT_BITS * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [HW_-1:0] disc,
  output logic [HW_-1:0] hits,
  output logic           any_hit
);
  localparam int unsigned HB = hf_pkg::HIT_BITS;

  logic [HW_-1:0] acc_q;
  logic [HW_-1:0] acc_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hits[c*HB +: HB]  = acc_q[c*HB +: HB] | disc[c*HB +: HB];
    assign acc_d[c*HB +: HB] = clr ? '0 : hits[c*HB +: HB];
  end

  assign any_hit = |hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/hf_fifo_ctrl.sv
module hf_fifo_ctrl #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] fill_cnt,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d;
  logic          state_en;

  always_comb begin
    push     = push_req & ~full_q;
    pop      = pop_req & (cnt_q != '0);
    state_en = push | pop;

    if (!push)                            wr_ptr_d = wr_ptr_q;
    else if (wr_ptr_q == AW'(DEPTH - 1))  wr_ptr_d = '0;
    else                                  wr_ptr_d = wr_ptr_q + 1'b1;

    if (!pop)                             rd_ptr_d = rd_ptr_q;
    else if (rd_ptr_q == AW'(DEPTH - 1))  rd_ptr_d = '0;
    else                                  rd_ptr_d = rd_ptr_q + 1'b1;

    cnt_d = cnt_q + CW'(push) - CW'(pop);

    if (full_q) full_d = (cnt_d != '0);
    else        full_d = (cnt_d == CW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
    end else if (state_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      full_q   <= full_d;
    end
  end

  assign wr_addr  = wr_ptr_q;
  assign rd_addr  = rd_ptr_q;
  assign fill_cnt = cnt_q;
  assign full     = full_q;
  assign empty    = (cnt_q == '0);
endmodule

// File: rtl/hf_frame_ram.sv
module hf_frame_ram #(
  parameter int unsigned W     = 160,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          rvalid
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;
  logic         rvalid_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= re;
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/hf_event_store.sv
module hf_event_store #(
  parameter int unsigned NCH    = 64,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned BCID_W = 24,
  parameter int unsigned HDR_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              acq_start,
  input  logic                              bx_strobe,
  input  logic [2*NCH-1:0]                  disc,
  input  logic [HDR_W-1:0]                  chip_id,
  input  logic                              rd_en,
  output logic                              rd_valid,
  output logic [2*NCH+BCID_W+HDR_W-1:0]     rd_frame,
  output logic                              full,
  output logic                              empty
);
  localparam int unsigned HIT_W   = hf_pkg::HIT_BITS * NCH;
  localparam int unsigned FRAME_W = hf_pkg::frame_width(NCH, BCID_W, HDR_W);
  localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW      = $clog2(DEPTH + 1);

  logic [HIT_W-1:0]   hits;
  logic               any_hit;
  logic [BCID_W-1:0]  bcid;
  logic               push_req;
  logic               push;
  logic               pop;
  logic [AW-1:0]      wr_addr;
  logic [AW-1:0]      rd_addr;
  logic [CW-1:0]      fill_cnt;
  logic [FRAME_W-1:0] wr_frame;

  assign push_req = bx_strobe & any_hit & ~acq_start;
  assign wr_frame = {chip_id, bcid, hits};

  hf_hit_accum #(.NCH(NCH)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acq_start | bx_strobe),
    .disc    (disc),
    .hits    (hits),
    .any_hit (any_hit)
  );

  hf_bx_counter #(.BW(BCID_W)) u_bx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acq_start),
    .step  (bx_strobe),
    .bcid  (bcid)
  );

  hf_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (rd_en),
    .push     (push),
    .pop      (pop),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .fill_cnt (fill_cnt),
    .full     (full),
    .empty    (empty)
  );

  hf_frame_ram #(.W(FRAME_W), .DEPTH(DEPTH)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (push),
    .waddr  (wr_addr),
    .wdata  (wr_frame),
    .re     (pop),
    .raddr  (rd_addr),
    .rdata  (rd_frame),
    .rvalid (rd_valid)
  );
endmodule

// File: rtl/hf_event_store_chk.sv
module hf_event_store_chk #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned BW    = 24,
  parameter int unsigned CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acq_start,
  input logic          bx_strobe,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          full,
  input logic          empty,
  input logic          push,
  input logic          pop,
  input logic [CW-1:0] fill_cnt,
  input logic [BW-1:0] bcid
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fill_cnt <= CW'(DEPTH)); // R7
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push); // R7
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (full && !rd_en) |=> full); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R8
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !empty) |=> rd_valid); // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!rd_en || empty) |=> !rd_valid); // R9
  AST_BCID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) acq_start |=> (bcid == '0)); // R6
  AST_ACQ_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) acq_start |-> !push); // R6
  AST_BCID_STEP: assert property (@(posedge clk) disable iff (!rst_n) (bx_strobe && !acq_start) |=> (bcid == BW'($past(bcid) + 1'b1))); // R5
  AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n) (push && pop) |=> $stable(fill_cnt)); // R10
endmodule

bind hf_event_store hf_event_store_chk #(.DEPTH(DEPTH), .BW(BCID_W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acq_start (acq_start),
  .bx_strobe (bx_strobe),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .full      (full),
  .empty     (empty),
  .push      (push),
  .pop       (pop),
  .fill_cnt  (fill_cnt),
  .bcid      (bcid)
);

// File: tb/hf_event_store_bench.sv
module hf_event_store_bench;
  localparam int NCH = 4, DEPTH = 8, BW = 8, HW = 8;
  localparam int FW = 2*NCH + BW + HW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, acq_start, bx_strobe, rd_en;
  logic [2*NCH-1:0] disc;
  logic [HW-1:0]  chip_id;
  logic           rd_valid, full, empty;
  logic [FW-1:0]  rd_frame;

  hf_event_store #(.NCH(NCH), .DEPTH(DEPTH), .BCID_W(BW), .HDR_W(HW)) u_hf_event_store (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .bx_strobe(bx_strobe),
    .disc(disc), .chip_id(chip_id), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_frame(rd_frame), .full(full), .empty(empty)
  );

  int checks = 0, errors = 0;
  int bx_model = 0;
  bit full_m = 1'b0;
  logic [FW-1:0] expq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void upd_full();
    if (full_m) full_m = (expq.size() != 0);
    else        full_m = (expq.size() == DEPTH);
  endfunction

  task automatic chk_flags(input string tag);
    chk({tag, " full"}, 32'(full), 32'(full_m));
    chk({tag, " empty"}, 32'(empty), 32'(expq.size() == 0));
  endtask

  // one crossing: level a on one cycle, level b on the strobe cycle
  task automatic crossing(input logic [2*NCH-1:0] a, input logic [2*NCH-1:0] b, input bit rd);
    logic [FW-1:0] exp_rd;
    bit did_pop;
    @(negedge clk); disc = a;
    @(negedge clk); disc = b; bx_strobe = 1'b1; rd_en = rd;
    did_pop = 1'b0;
    exp_rd = '0;
    if (rd && expq.size() > 0) begin exp_rd = expq.pop_front(); did_pop = 1'b1; end
    if (((a | b) != 0) && !full_m) expq.push_back({chip_id, BW'(bx_model), a | b});
    bx_model++;
    upd_full();
    @(negedge clk); disc = '0; bx_strobe = 1'b0; rd_en = 1'b0;
    if (rd) begin
      chk("R10 R9 valid", 32'(rd_valid), 32'(did_pop));
      if (did_pop) chk("R10 R2 frame", 32'(rd_frame), 32'(exp_rd));
    end
    chk_flags("R3 R7 R8");
  endtask

  task automatic rd_one();
    logic [FW-1:0] e;
    bit has;
    @(negedge clk); rd_en = 1'b1;
    has = (expq.size() > 0);
    e = '0;
    if (has) e = expq.pop_front();
    upd_full();
    @(negedge clk); rd_en = 1'b0;
    chk("R9 valid", 32'(rd_valid), 32'(has));
    if (has) chk("R2 R4 R5 R9 frame", 32'(rd_frame), 32'(e));
    chk_flags("R8");
  endtask

  task automatic drain();
    while (expq.size() > 0) rd_one();
  endtask

  task automatic acq(input bit with_strobe, input logic [2*NCH-1:0] lvl);
    @(negedge clk); acq_start = 1'b1; bx_strobe = with_strobe; disc = lvl;
    @(negedge clk); acq_start = 1'b0; bx_strobe = 1'b0; disc = '0;
    bx_model = 0;
    chk_flags("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acq_start = 1'b0; bx_strobe = 1'b0; rd_en = 1'b0;
    disc = '0; chip_id = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty after release", 32'(empty), 32'd1);

    // R6: levels gathered before acq_start, and a strobe coinciding with it, leave no frame
    @(negedge clk); disc = 8'hC3;
    acq(1'b1, 8'h3C);
    crossing(8'h00, 8'h00, 1'b0);          // R3: quiet crossing, no frame
    chk("R6 R3 still empty", 32'(empty), 32'd1);
    acq(1'b0, 8'h00);

    // fill: quiet crossings, double-pulse crossings, header changes
    crossing(8'h01, 8'h00, 1'b0);
    chip_id = 8'hA3;
    crossing(8'h00, 8'h00, 1'b0);
    crossing(8'h30, 8'h0C, 1'b0);          // R4: two active cycles, one frame
    crossing(8'h00, 8'h80, 1'b0);
    for (int k = 0; expq.size() < DEPTH; k++) begin
      chip_id = 8'(k * 37 + 1);
      crossing(8'(k + 2), 8'(k << 4), 1'b0);
    end
    chk("R7 full at depth", 32'(full), 32'd1);
    crossing(8'hFF, 8'h00, 1'b0);          // R7: ignored
    rd_one();
    chk("R8 full after partial read", 32'(full), 32'd1);
    crossing(8'h11, 8'h22, 1'b0);          // R8: still blocked
    drain();
    chk("R8 full cleared", 32'(full), 32'd0);
    rd_one();                               // R9: read while empty

    // R10: capture and read together
    crossing(8'h05, 8'h00, 1'b0);
    crossing(8'h50, 8'h00, 1'b0);
    crossing(8'h0A, 8'hA0, 1'b1);
    drain();

    // sweep every nonzero level pattern; crossing counter wraps (R5)
    for (int pat = 1; pat < 256; pat++) begin
      chip_id = 8'(pat) ^ 8'h5C;
      crossing(8'(pat) & 8'h33, 8'(pat) & 8'hCC, 1'b0);
      if (pat % 5 == 0) crossing(8'h00, 8'h00, 1'b0);
      if (expq.size() == DEPTH) drain();
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule